// File: doc/BRIEF.md
# Eight-Bit ALU With Carry Select

This block is the purely combinational arithmetic/logic core of a small accumulator-style datapath. It has two 8-bit operands and a 3-bit function code. It returns an 8-bit result and a carry out. Internally the byte is handled as two 4-bit slices, and the carry out of the lower slice is the carry in of the upper slice.

The carry into the arithmetic is taken from one of two places, picked by a single select bit. It is either a constant 1, or a carry bit that the surrounding datapath stored from the previous operation. That stored bit lives outside this block. A constant 0 is not offered directly. Software gets a zero carry by first running a function that returns carry 0 (for example clear) and letting that value be stored. With this scheme the same adder does add, add-plus-one, add-with-carry, and two's-complement subtraction in both operand orders.

Top module: `alu8_csel`

## Requirements
- R1: Function code 000 (clear) drives result 0x00 and carry out 0, whatever the operands and carry inputs are.
- R2: When `csel` is 1 the carry-in is 1, and `c_stored` has no effect on the result or the carry out.
- R3: When `csel` is 0 the carry-in equals `c_stored`.
- R4: Function code 011 gives the 9-bit sum {cout, y} = a + b + carry-in.
- R5: Function code 010 gives {cout, y} = a + (~b) + carry-in. With carry-in 1, y is a - b modulo 256 and cout is 1 exactly when a >= b.
- R6: Function code 001 gives {cout, y} = b + (~a) + carry-in. With carry-in 1, y is b - a modulo 256 and cout is 1 exactly when b >= a.
- R7: Function codes 100, 101 and 110 give a XOR b, a OR b and a AND b. Carry out is 0 and the carry-in has no effect.
- R8: Function code 111 drives result 0xFF and carry out 0.
- R9: A carry generated in bits 3..0 reaches bits 7..4 in the same evaluation, so 0x0F + 0x01 gives 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| fn | input | 3 | Function code (see R1, R4-R8) |
| csel | input | 1 | Carry-in select: 1 = constant one, 0 = stored carry |
| c_stored | input | 1 | Carry bit kept by the surrounding datapath |
| y | output | 8 | Result byte |
| cout | output | 1 | Carry out |

## Verification
Two things happen in the same evaluation and interact: the selected carry-in, and the carry passed from the low slice to the high slice. The bench provokes this with operands whose low nibble is all ones. It then toggles `csel` and `c_stored` so that the carry-in alone decides whether a carry ripples into the upper nibble and out. The bench also keeps its own carry flop, loaded from `cout` on every clock. This lets it chain a two-byte add and random sequences in which each operation's carry-in is the previous carry out. A behavioural model compares result and carry on every cycle.

// File: rtl/alu8_csel.sv
module alu8_csel #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  input  logic         csel,
  input  logic         c_stored,
  output logic [W-1:0] y,
  output logic         cout
);
  localparam int NS = W / SW;

  logic         cin;
  logic         arith;
  logic [W-1:0] opx, opy, sum;
  logic [NS:0]  ch;

  assign cin   = csel ? 1'b1 : c_stored;
  assign arith = (fn == 3'b001) || (fn == 3'b010) || (fn == 3'b011);

  always_comb begin
    case (fn)
      3'b001:  begin opx = b; opy = ~a; end
      3'b010:  begin opx = a; opy = ~b; end
      default: begin opx = a; opy = b;  end
    endcase
  end

  assign ch[0] = cin;

  genvar i;
  generate
    for (i = 0; i < NS; i++) begin : g_slice
      logic [SW:0] t;
      assign t = {1'b0, opx[i*SW +: SW]} + {1'b0, opy[i*SW +: SW]}
               + {{SW{1'b0}}, ch[i]};
      assign sum[i*SW +: SW] = t[SW-1:0];
      assign ch[i+1]         = t[SW];
    end
  endgenerate

  always_comb begin
    case (fn)
      3'b000:  y = '0;
      3'b100:  y = a ^ b;
      3'b101:  y = a | b;
      3'b110:  y = a & b;
      3'b111:  y = '1;
      default: y = sum;
    endcase
  end

  assign cout = arith ? ch[NS] : 1'b0;

  always_comb begin
    if (fn == 3'b000) begin
      assert_clear_R1: assert (y == '0 && !cout);
    end
    if (fn == 3'b011) begin
      assert_add_R4: assert ({cout, y} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)));
    end
    if (fn == 3'b010 && cin) begin
      assert_sub_R5: assert (y == W'(a - b) && cout == (a >= b));
    end
    if (fn[2]) begin
      assert_nocarry_R7: assert (!cout);
    end
  end
endmodule

// File: tb/tb_alu8_csel.sv
module tb_alu8_csel;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] a = 0, b = 0;
  logic [2:0] fn = 0;
  logic       csel = 0, cs_drv = 0, use_reg = 0;
  logic       c_reg;
  logic       c_stored;
  logic [7:0] y;
  logic       cout;
  int         nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  assign c_stored = use_reg ? c_reg : cs_drv;

  always_ff @(posedge clk) begin
    if (rst) c_reg <= 1'b0;
    else     c_reg <= cout;
  end

  alu8_csel dut (.a(a), .b(b), .fn(fn), .csel(csel), .c_stored(c_stored), .y(y), .cout(cout));

  function automatic int model(int x, int z, int f, int ci);
    case (f)
      0: return 0;
      1: return z + ((~x) & 255) + ci;
      2: return x + ((~z) & 255) + ci;
      3: return x + z + ci;
      4: return x ^ z;
      5: return x | z;
      6: return x & z;
      default: return 255;
    endcase
  endfunction

  task automatic step(input logic [7:0] ia, input logic [7:0] ib, input logic [2:0] ifn,
                      input logic isel, input logic ics, input logic ireg, input string tag);
    int ci, r;
    @(negedge clk);
    a = ia; b = ib; fn = ifn; csel = isel; cs_drv = ics; use_reg = ireg;
    #2;
    ci = isel ? 1 : int'(c_stored);
    r  = model(int'(ia), int'(ib), int'(ifn), ci);
    nchk++;
    if (y !== 8'(r) || cout !== r[8]) begin
      nerr++;
      $display("FAIL %s: fn=%b a=%h b=%h got y=%h c=%b exp y=%h c=%b",
               tag, ifn, ia, ib, y, cout, 8'(r), r[8]);
    end
  endtask

  initial begin
    fork
      begin
        #4000000;
        nerr++; nchk++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    rst = 0;
    step(8'h00, 8'h00, 3'b000, 0, 0, 0, "R1 reset state");
    step(8'hFF, 8'hFF, 3'b000, 1, 1, 0, "R1 clear");
    step(8'h12, 8'h34, 3'b011, 0, 0, 0, "R3 R4 add cin0");
    step(8'h12, 8'h34, 3'b011, 0, 1, 0, "R3 stored carry");
    step(8'h12, 8'h34, 3'b011, 1, 0, 0, "R2 force one");
    step(8'h12, 8'h34, 3'b011, 1, 1, 0, "R2 ignore stored");
    step(8'h0F, 8'h01, 3'b011, 0, 0, 0, "R9 nibble carry");
    step(8'h0F, 8'h00, 3'b011, 1, 0, 0, "R9 R2 cin ripple");
    step(8'h0F, 8'h00, 3'b011, 0, 0, 0, "R9 R3 no ripple");
    step(8'hFF, 8'h01, 3'b011, 0, 0, 0, "R4 carry out");
    step(8'h50, 8'h20, 3'b010, 1, 0, 0, "R5 a-b");
    step(8'h20, 8'h50, 3'b010, 1, 0, 0, "R5 borrow");
    step(8'h50, 8'h50, 3'b010, 1, 0, 0, "R5 equal");
    step(8'h20, 8'h50, 3'b001, 1, 0, 0, "R6 b-a");
    step(8'h50, 8'h20, 3'b001, 1, 0, 0, "R6 borrow");
    step(8'h50, 8'h20, 3'b001, 0, 0, 0, "R6 cin0");
    step(8'hA5, 8'h3C, 3'b100, 1, 1, 0, "R7 xor");
    step(8'hA5, 8'h3C, 3'b101, 0, 1, 0, "R7 or");
    step(8'hA5, 8'h3C, 3'b110, 1, 0, 0, "R7 and");
    step(8'hFF, 8'hFF, 3'b110, 1, 1, 0, "R7 and no carry");
    step(8'h00, 8'h00, 3'b111, 1, 1, 0, "R8 ones");
    step(8'h00, 8'h00, 3'b000, 0, 0, 0, "R1 zero carry");
    step(8'hFF, 8'h01, 3'b011, 0, 0, 1, "R3 chain low");
    step(8'h12, 8'h00, 3'b011, 0, 0, 1, "R3 R9 chain high");
    for (int k = 0; k < 400; k++) begin
      step(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           "R4 R5 R6 R7 random");
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule